// File: doc/BRIEF.md
# Slave Request Error Monitor

This block sits beside a burst-capable, memory-mapped slave port with sixteen byte lanes and watches the requests that the port accepts. It never forwards, changes or stalls a request. Each accepted read, and the first beat of each accepted write, is checked for three kinds of fault. The burst length may be too long. The byte-enable pattern may be malformed. The address may miss every enabled address-mapping window. Writes are tracked beat by beat, so the byte enable of the final beat can be checked against the one legal form of an over-long write burst.

Each fault type sets its own sticky bit in a status register. Software clears a bit by writing 1 to it. A companion enable register chooses which status bits may raise the single maintenance interrupt line. Both registers sit behind a small register port with a one-cycle read latency. Four address windows, each with a base, a mask and an enable, come in as inputs from the surrounding logic.

Top module: `sreq_err_monitor`

## Requirements
- R1: After a synchronous active-low reset, the status register and the enable register both read as zero, and `irq` is low.
- R2: The status register sits at byte offset 0x10500 with bit 0 = read out of bounds, bit 1 = write out of bounds, bit 2 = write burst length invalid, bit 3 = write byte enable invalid, bit 4 = read byte enable invalid, and bit 5 = read burst length invalid. Bits [31:6] read as zero. A fault becomes visible in the status register on the clock edge that accepts the beat deciding it.
- R3: Writing a 1 to a status bit clears it. Writing a 0 leaves it unchanged. A set bit stays set until it is cleared.
- R4: The enable register at byte offset 0x10504 holds bits [5:0], at the same positions as the status bits, and bits [31:6] read as zero. A read of the register port returns data on the clock edge after `csr_read` is sampled, and any unmapped offset reads as zero.
- R5: `irq` is high exactly when at least one status bit and the matching enable bit are both set.
- R6: An accepted read whose burst count is greater than 16 sets bit 5.
- R7: A write burst whose count is greater than 16 sets bit 2 when its final beat is accepted. The one exception is a burst whose first beat has byte enable 0xFF00 and whose final beat has byte enable 0x00FF; that burst does not set the bit. Write bursts of 16 beats or fewer never set bit 2.
- R8: Window i matches when its enable is set and (address AND mask) equals (base AND mask). An accepted read that matches no window sets bit 0, and an accepted first write beat that matches no window sets bit 1.
- R9: A byte enable is legal only if it is nonzero, its set bits form one contiguous run of 1, 2, 4, 8 or 16 lanes, and the run starts at a lane index that is a multiple of its length. An illegal byte enable on an accepted read sets bit 4, and an illegal one on the first beat of an accepted write sets bit 3.
- R10: When a fault and a software clear hit the same status bit in the same cycle, the bit ends up set.
- R11: A request cycle with `s_waitreq` high is not a transfer and changes no status bit.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| s_address | input | 32 | Byte address of the observed request |
| s_read | input | 1 | Read request on the observed port |
| s_write | input | 1 | Write beat on the observed port |
| s_waitreq | input | 1 | Slave stall; a beat transfers only while this is low |
| s_burstcount | input | 8 | Burst length in beats |
| s_byteenable | input | 16 | Lane enables of the current beat |
| win_base | input | 128 | Four window bases, window 0 in the low 32 bits |
| win_mask | input | 128 | Four window masks, same packing |
| win_en | input | 4 | Per-window enable |
| csr_addr | input | 20 | Register port byte address |
| csr_read | input | 1 | Register read strobe |
| csr_write | input | 1 | Register write strobe |
| csr_wdata | input | 32 | Register write data |
| csr_rdata | output | 32 | Register read data, valid one cycle after the strobe |
| irq | output | 1 | Maintenance interrupt |

## Verification
The hardware fault path and the software clear path can both act on the status register in the same clock cycle. The bench provokes this by raising an accepted out-of-bounds read in the same cycle as a status write that clears that bit together with another set bit. It then requires the faulted bit to stay set and the other bit to go clear. The same merge is covered more broadly by random traffic, where every status readback is compared with a bench model and then cleared, with the interrupt level judged against a random enable mask.

// File: rtl/sreq_err_pkg.sv
// Package: shared constants for the slave request error monitor.
// Holds the status bit positions (software decodes them) and register offsets.
package sreq_err_pkg;
    localparam int NUM_ERR   = 6;
    localparam int ERR_RD_OOB = 0;
    localparam int ERR_WR_OOB = 1;
    localparam int ERR_WR_BC  = 2;
    localparam int ERR_WR_BE  = 3;
    localparam int ERR_RD_BE  = 4;
    localparam int ERR_RD_BC  = 5;

    localparam int CSR_DW     = 32;
    localparam logic [19:0] STATUS_OFS = 20'h10500;
    localparam logic [19:0] ENABLE_OFS = 20'h10504;

    typedef logic [NUM_ERR-1:0] err_vec_t;
endpackage

// File: rtl/sreq_window_match.sv
// Module: sreq_window_match
// Compares one address against NWIN base/mask windows and reports whether any
// enabled window matches. Purely combinational.
// Assumes windows are packed flat, window 0 in the least significant slice.
module sreq_window_match #(
    parameter int AW   = 32,
    parameter int NWIN = 4
) (
    input  logic [AW-1:0]      addr,
    input  logic [NWIN*AW-1:0] win_base,
    input  logic [NWIN*AW-1:0] win_mask,
    input  logic [NWIN-1:0]    win_en,
    output logic               hit
);
    logic [NWIN-1:0] win_hit;

    for (genvar g = 0; g < NWIN; g++) begin : g_win
        logic [AW-1:0] base_g;
        logic [AW-1:0] mask_g;
        assign base_g = win_base[g*AW +: AW];
        assign mask_g = win_mask[g*AW +: AW];
        // Per-window match: enabled and masked address equals masked base.
        assign win_hit[g] = win_en[g] && ((addr & mask_g) == (base_g & mask_g));
    end

    assign hit = |win_hit;

    // R8: with every window disabled nothing can be in bounds.
    always_comb begin
        a_r8_disabled_miss: assert (win_en != '0 || !hit);
    end
endmodule

// File: rtl/sreq_req_classifier.sv
// Module: sreq_req_classifier
// Watches accepted beats on the observed slave port and emits a one-cycle
// fault vector. Reads are checked in the accepting cycle. Writes are checked on
// their first beat, and long write bursts are tracked to their final beat.
// Assumes a read does not arrive while a write burst is still in progress,
// and that burst count and address are held stable during a write burst.
module sreq_req_classifier
    import sreq_err_pkg::*;
#(
    parameter int LANES     = 16,
    parameter int BCW       = 8,
    parameter int MAX_BURST = 16
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             s_read,
    input  logic             s_write,
    input  logic             s_waitreq,
    input  logic [BCW-1:0]   s_burstcount,
    input  logic [LANES-1:0] s_byteenable,
    input  logic             addr_hit,
    output err_vec_t         set_vec
);
    localparam logic [LANES-1:0] LO_HALF = LANES'((LANES+1)'(1) << (LANES/2)) - LANES'(1);
    localparam logic [LANES-1:0] HI_HALF = ~LO_HALF;
    localparam logic [BCW-1:0]   BC_MAX  = BCW'(MAX_BURST);

    logic           rd_acc, wr_acc, wr_first, wr_next, wr_final;
    logic           bc_long, be_ok, tail_ok;
    logic           wb_active, wb_long, wb_first_hi;
    logic [BCW-1:0] beats_left;

    // Byte enable legality: one aligned contiguous run of power-of-two length.
    function automatic logic be_legal(input logic [LANES-1:0] be);
        int         cnt;
        int         lo;
        logic       found;
        logic [LANES:0] run;
        cnt   = 0;
        lo    = 0;
        found = 1'b0;
        for (int i = 0; i < LANES; i++) begin
            if (be[i]) begin
                cnt = cnt + 1;
                if (!found) begin
                    lo    = i;
                    found = 1'b1;
                end
            end
        end
        run = ((LANES+1)'(1) << cnt) - (LANES+1)'(1);
        run = run << lo;
        return (cnt != 0) && ((cnt & (cnt - 1)) == 0) &&
               ((lo & (cnt - 1)) == 0) && (be == run[LANES-1:0]);
    endfunction

    // Beat acceptance qualifiers.
    always_comb begin
        rd_acc   = s_read && !s_waitreq;
        wr_acc   = s_write && !s_waitreq;
        wr_first = wr_acc && !wb_active;
        wr_next  = wr_acc && wb_active;
        wr_final = wr_next && (beats_left == BCW'(1));
        bc_long  = s_burstcount > BC_MAX;
        be_ok    = be_legal(s_byteenable);
        tail_ok  = wb_first_hi && (s_byteenable == LO_HALF);
    end

    // Fault vector for the beat being accepted this cycle.
    always_comb begin
        set_vec             = '0;
        set_vec[ERR_RD_OOB] = rd_acc && !addr_hit;
        set_vec[ERR_RD_BC]  = rd_acc && bc_long;
        set_vec[ERR_RD_BE]  = rd_acc && !be_ok;
        set_vec[ERR_WR_OOB] = wr_first && !addr_hit;
        set_vec[ERR_WR_BE]  = wr_first && !be_ok;
        set_vec[ERR_WR_BC]  = wr_final && wb_long && !tail_ok;
    end

    // Write burst tracker: remembers length class and first-beat shape.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            wb_active   <= 1'b0;
            wb_long     <= 1'b0;
            wb_first_hi <= 1'b0;
            beats_left  <= '0;
        end else if (wr_first && (s_burstcount > BCW'(1))) begin
            wb_active   <= 1'b1;
            wb_long     <= bc_long;
            wb_first_hi <= (s_byteenable == HI_HALF);
            beats_left  <= s_burstcount - BCW'(1);
        end else if (wr_next) begin
            beats_left <= beats_left - BCW'(1);
            if (beats_left == BCW'(1)) begin
                wb_active <= 1'b0;
            end
        end
    end

    // R11: a stalled cycle never reports a fault.
    a_r11_stall_quiet: assert property (@(posedge clk) disable iff (!rst_n)
        s_waitreq |-> (set_vec == '0));

    // R7: the beat counter only moves on accepted write beats.
    a_r7_count_hold: assert property (@(posedge clk) disable iff (!rst_n)
        (wb_active && !wr_acc) |=> $stable(beats_left));

    // R9: an all-zero first write enable is always reported.
    a_r9_zero_be_flag: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_first && s_byteenable == '0) |-> set_vec[ERR_WR_BE]);
endmodule

// File: rtl/sreq_err_regs.sv
// Module: sreq_err_regs
// Sticky status register (write 1 to clear), enable register and interrupt.
// Hardware set has priority over a software clear in the same cycle.
// Assumes byte addressing of the register port and whole-word accesses.
module sreq_err_regs
    import sreq_err_pkg::*;
#(
    parameter int CSR_AW = 20
) (
    input  logic              clk,
    input  logic              rst_n,
    input  err_vec_t          set_vec,
    input  logic [CSR_AW-1:0] csr_addr,
    input  logic              csr_read,
    input  logic              csr_write,
    input  logic [CSR_DW-1:0] csr_wdata,
    output logic [CSR_DW-1:0] csr_rdata,
    output err_vec_t          status_o,
    output err_vec_t          enable_o,
    output logic              irq
);
    localparam logic [CSR_AW-1:0] ST_ADDR = CSR_AW'(STATUS_OFS);
    localparam logic [CSR_AW-1:0] EN_ADDR = CSR_AW'(ENABLE_OFS);

    err_vec_t status_q, enable_q, clr_vec;
    logic     wr_st, wr_en;
    logic     unused_wdata;

    assign unused_wdata = ^csr_wdata[CSR_DW-1:NUM_ERR];

    // Decode register writes and form the clear mask.
    always_comb begin
        wr_st   = csr_write && (csr_addr == ST_ADDR);
        wr_en   = csr_write && (csr_addr == EN_ADDR);
        clr_vec = wr_st ? csr_wdata[NUM_ERR-1:0] : '0;
    end

    // Status bits: cleared by software, set by faults, set wins.
    always_ff @(posedge clk) begin
        if (!rst_n) status_q <= '0;
        else        status_q <= (status_q & ~clr_vec) | set_vec;
    end

    // Enable bits: plain read/write storage.
    always_ff @(posedge clk) begin
        if (!rst_n)     enable_q <= '0;
        else if (wr_en) enable_q <= csr_wdata[NUM_ERR-1:0];
    end

    // Registered read data, zero for unmapped offsets and reserved bits.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            csr_rdata <= '0;
        end else if (csr_read) begin
            if (csr_addr == ST_ADDR)      csr_rdata <= CSR_DW'(status_q);
            else if (csr_addr == EN_ADDR) csr_rdata <= CSR_DW'(enable_q);
            else                          csr_rdata <= '0;
        end
    end

    assign status_o = status_q;
    assign enable_o = enable_q;
    assign irq      = |(status_q & enable_q);

    // R10: every fault raised in a cycle is present afterwards.
    a_r10_set_wins: assert property (@(posedge clk) disable iff (!rst_n)
        (set_vec != '0) |=> ((status_q & $past(set_vec)) == $past(set_vec)));

    // R3: a set bit only drops when software wrote 1 to it.
    a_r3_sticky: assert property (@(posedge clk) disable iff (!rst_n)
        1'b1 |=> ((($past(status_q) & ~$past(clr_vec)) & ~status_q) == '0));

    // R4: enable bits change only on a write to their offset.
    a_r4_enable_hold: assert property (@(posedge clk) disable iff (!rst_n)
        !wr_en |=> $stable(enable_q));
endmodule

// File: rtl/sreq_err_monitor.sv
// Module: sreq_err_monitor (top)
// Observes a burst-capable slave port, classifies faulty requests, keeps the
// sticky status / enable pair and drives one interrupt.
// Assumes the observed port follows a stall-by-waitrequest handshake.
module sreq_err_monitor
    import sreq_err_pkg::*;
#(
    parameter int AW        = 32,
    parameter int LANES     = 16,
    parameter int BCW       = 8,
    parameter int NWIN      = 4,
    parameter int CSR_AW    = 20,
    parameter int MAX_BURST = 16
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic [AW-1:0]      s_address,
    input  logic               s_read,
    input  logic               s_write,
    input  logic               s_waitreq,
    input  logic [BCW-1:0]     s_burstcount,
    input  logic [LANES-1:0]   s_byteenable,
    input  logic [NWIN*AW-1:0] win_base,
    input  logic [NWIN*AW-1:0] win_mask,
    input  logic [NWIN-1:0]    win_en,
    input  logic [CSR_AW-1:0]  csr_addr,
    input  logic               csr_read,
    input  logic               csr_write,
    input  logic [CSR_DW-1:0]  csr_wdata,
    output logic [CSR_DW-1:0]  csr_rdata,
    output logic               irq
);
    logic     addr_hit;
    err_vec_t set_vec, status, enable;

    sreq_window_match #(.AW(AW), .NWIN(NWIN)) u_win (
        .addr     (s_address),
        .win_base (win_base),
        .win_mask (win_mask),
        .win_en   (win_en),
        .hit      (addr_hit)
    );

    sreq_req_classifier #(.LANES(LANES), .BCW(BCW), .MAX_BURST(MAX_BURST)) u_cls (
        .clk          (clk),
        .rst_n        (rst_n),
        .s_read       (s_read),
        .s_write      (s_write),
        .s_waitreq    (s_waitreq),
        .s_burstcount (s_burstcount),
        .s_byteenable (s_byteenable),
        .addr_hit     (addr_hit),
        .set_vec      (set_vec)
    );

    sreq_err_regs #(.CSR_AW(CSR_AW)) u_regs (
        .clk       (clk),
        .rst_n     (rst_n),
        .set_vec   (set_vec),
        .csr_addr  (csr_addr),
        .csr_read  (csr_read),
        .csr_write (csr_write),
        .csr_wdata (csr_wdata),
        .csr_rdata (csr_rdata),
        .status_o  (status),
        .enable_o  (enable),
        .irq       (irq)
    );

    // R6: an accepted over-long read is recorded on the next edge.
    a_r6_rd_burst_flag: assert property (@(posedge clk) disable iff (!rst_n)
        (s_read && !s_waitreq && (s_burstcount > BCW'(MAX_BURST))) |=> status[ERR_RD_BC]);

    // R5: with nothing enabled the interrupt stays low.
    a_r5_irq_quiet: assert property (@(posedge clk) disable iff (!rst_n)
        (enable == '0) |-> !irq);
endmodule

// File: tb/tb_sreq_err_monitor.sv
module tb_sreq_err_monitor;
    localparam int CLK_PERIOD = 10;
    localparam logic [19:0] ST = 20'h10500;
    localparam logic [19:0] EN = 20'h10504;

    logic         clk = 1'b0;
    logic         rst_n = 1'b0;
    logic [31:0]  s_address = '0;
    logic         s_read = 1'b0, s_write = 1'b0, s_waitreq = 1'b0;
    logic [7:0]   s_burstcount = 8'd1;
    logic [15:0]  s_byteenable = 16'hFFFF;
    logic [127:0] win_base, win_mask;
    logic [3:0]   win_en;
    logic [19:0]  csr_addr = '0;
    logic         csr_read = 1'b0, csr_write = 1'b0;
    logic [31:0]  csr_wdata = '0;
    logic [31:0]  csr_rdata;
    logic         irq;

    logic [31:0] wb [4];
    logic [31:0] wm [4];
    logic        we [4];

    int       n_checks = 0;
    int       n_fail = 0;
    logic [5:0] exp_st = '0;

    sreq_err_monitor dut (
        .clk(clk), .rst_n(rst_n), .s_address(s_address), .s_read(s_read),
        .s_write(s_write), .s_waitreq(s_waitreq), .s_burstcount(s_burstcount),
        .s_byteenable(s_byteenable), .win_base(win_base), .win_mask(win_mask),
        .win_en(win_en), .csr_addr(csr_addr), .csr_read(csr_read),
        .csr_write(csr_write), .csr_wdata(csr_wdata), .csr_rdata(csr_rdata),
        .irq(irq)
    );

    always #(CLK_PERIOD/2) clk = ~clk;

    initial begin
        wb[0] = 32'h1000_0000; wm[0] = 32'hF000_0000; we[0] = 1'b1;
        wb[1] = 32'h2000_0000; wm[1] = 32'hFF00_0000; we[1] = 1'b1;
        wb[2] = 32'h3000_0000; wm[2] = 32'hF000_0000; we[2] = 1'b0;
        wb[3] = 32'h4000_0000; wm[3] = 32'hFFFF_0000; we[3] = 1'b1;
        win_base = {wb[3], wb[2], wb[1], wb[0]};
        win_mask = {wm[3], wm[2], wm[1], wm[0]};
        win_en   = {we[3], we[2], we[1], we[0]};
    end

    function automatic bit f_be_legal(input logic [15:0] be);
        for (int sz = 1; sz <= 16; sz = sz * 2)
            for (int off = 0; off < 16; off += sz)
                if (be == 16'(((1 << sz) - 1) << off)) return 1'b1;
        return 1'b0;
    endfunction

    function automatic bit f_in_bounds(input logic [31:0] a);
        for (int i = 0; i < 4; i++)
            if (we[i] && ((a & wm[i]) == (wb[i] & wm[i]))) return 1'b1;
        return 1'b0;
    endfunction

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        n_checks++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: actual 0x%08h expected 0x%08h", req, act, exp);
        end
    endtask

    task automatic csr_wr(input logic [19:0] a, input logic [31:0] d);
        @(negedge clk);
        csr_write = 1'b1; csr_addr = a; csr_wdata = d;
        @(negedge clk);
        csr_write = 1'b0;
    endtask

    task automatic csr_rd(input logic [19:0] a, output logic [31:0] d);
        @(negedge clk);
        csr_read = 1'b1; csr_addr = a;
        @(negedge clk);
        csr_read = 1'b0;
        d = csr_rdata;
    endtask

    task automatic do_read(input logic [31:0] a, input logic [7:0] bc,
                           input logic [15:0] be, input int stall);
        @(negedge clk);
        s_read = 1'b1; s_address = a; s_burstcount = bc; s_byteenable = be;
        s_waitreq = 1'b1;
        repeat (stall) @(negedge clk);
        s_waitreq = 1'b0;
        @(negedge clk);
        s_read = 1'b0;
        if (!f_in_bounds(a)) exp_st[0] = 1'b1;
        if (!f_be_legal(be)) exp_st[4] = 1'b1;
        if (bc > 8'd16)      exp_st[5] = 1'b1;
    endtask

    task automatic do_write(input logic [31:0] a, input logic [7:0] bc,
                            input logic [15:0] be_first, input logic [15:0] be_last,
                            input int stall);
        int nb;
        nb = (bc == 0) ? 1 : int'(bc);
        for (int b = 0; b < nb; b++) begin
            @(negedge clk);
            s_write = 1'b1; s_address = a; s_burstcount = bc;
            s_byteenable = (b == 0) ? be_first : ((b == nb - 1) ? be_last : 16'hFFFF);
            if (b == nb / 2 && stall > 0) begin
                s_waitreq = 1'b1;
                repeat (stall) @(negedge clk);
                s_waitreq = 1'b0;
            end
        end
        @(negedge clk);
        s_write = 1'b0;
        if (!f_in_bounds(a))       exp_st[1] = 1'b1;
        if (!f_be_legal(be_first)) exp_st[3] = 1'b1;
        if (bc > 8'd16 && !(be_first == 16'hFF00 && be_last == 16'h00FF)) exp_st[2] = 1'b1;
    endtask

    // Read status, judge irq under a random enable, then clear everything.
    task automatic verify(input string req);
        logic [31:0] v;
        logic [5:0]  en;
        csr_rd(ST, v);
        check(req, v, {26'b0, exp_st});
        en = 6'($urandom);
        csr_wr(EN, {26'b0, en});
        check({req, " R5 irq"}, {31'b0, irq}, {31'b0, |(exp_st & en)});
        csr_wr(ST, 32'h3F);
        exp_st = '0;
        check("R3 clear-all", {31'b0, irq}, 32'd0);
    endtask

    initial begin
        logic [31:0] v;
        void'($urandom(32'd2024));
        repeat (3) @(negedge clk);
        rst_n = 1'b1;

        // R1 reset state
        check("R1 irq", {31'b0, irq}, 32'd0);
        csr_rd(ST, v); check("R1 status", v, 32'd0);
        csr_rd(EN, v); check("R1 enable", v, 32'd0);

        // R4 enable register width and read port behaviour
        csr_wr(EN, 32'hFFFF_FFFF);
        csr_rd(EN, v); check("R4 enable all ones", v, 32'h3F);
        csr_wr(EN, 32'h15);
        csr_rd(EN, v); check("R4 enable pattern", v, 32'h15);
        csr_rd(20'h10508, v); check("R4 unmapped", v, 32'd0);
        csr_wr(EN, 32'h0);

        // R2 reserved status bits, write ignored
        csr_wr(ST, 32'hFFFF_FFC0);
        csr_rd(ST, v); check("R2 reserved", v, 32'd0);

        // R8 windows
        do_read(32'h1000_0040, 8'd1, 16'hFFFF, 0); verify("R8 read win0");
        do_read(32'h3000_0000, 8'd1, 16'hFFFF, 0); verify("R8 read disabled win");
        do_write(32'h5000_0000, 8'd1, 16'hFFFF, 16'hFFFF, 0); verify("R8 write unmapped");
        do_read(32'h4000_FFF0, 8'd1, 16'h000F, 0); verify("R8 read win3 top");
        do_read(32'h4001_0000, 8'd1, 16'h000F, 0); verify("R8 read past win3");
        do_read(32'h20FF_0000, 8'd4, 16'hFFFF, 0); verify("R8 read win1");

        // R6 read burst length
        do_read(32'h1000_0000, 8'd16, 16'hFFFF, 0); verify("R6 read 16");
        do_read(32'h1000_0000, 8'd17, 16'hFFFF, 0); verify("R6 read 17");

        // R9 byte enable forms
        do_read(32'h1000_0000, 8'd1, 16'h0000, 0); verify("R9 read zero be");
        do_read(32'h1000_0000, 8'd1, 16'h0006, 0); verify("R9 read misaligned be");
        do_read(32'h1000_0000, 8'd1, 16'h0007, 0); verify("R9 read three lanes");
        do_read(32'h1000_0000, 8'd1, 16'h00F0, 0); verify("R9 read aligned four");
        do_write(32'h1000_0000, 8'd1, 16'h0300, 16'h0300, 0); verify("R9 write aligned two");
        do_write(32'h1000_0000, 8'd1, 16'h0FF0, 16'h0FF0, 0); verify("R9 write misaligned eight");

        // R7 long write bursts
        do_write(32'h1000_0000, 8'd20, 16'hFF00, 16'h00FF, 0); verify("R7 exempt burst");
        do_write(32'h1000_0000, 8'd20, 16'hFF00, 16'h00FF, 3); verify("R7 exempt burst stalled");
        do_write(32'h1000_0000, 8'd20, 16'hFF00, 16'hFFFF, 0); verify("R7 bad last beat");
        do_write(32'h1000_0000, 8'd18, 16'hFFFF, 16'h00FF, 2); verify("R7 bad first beat");
        do_write(32'h1000_0000, 8'd16, 16'hFFFF, 16'h0001, 0); verify("R7 sixteen beats");

        // R3 write-one-to-clear on individual bits
        do_read(32'h3000_0000, 8'd17, 16'hFFFF, 0);
        csr_rd(ST, v); check("R3 built", v, 32'h21);
        csr_wr(ST, 32'h0);
        csr_rd(ST, v); check("R3 zero write keeps", v, 32'h21);
        csr_wr(ST, 32'h20);
        csr_rd(ST, v); check("R3 partial clear", v, 32'h01);

        // R5 irq follows enable
        csr_wr(EN, 32'h01);
        check("R5 irq enabled", {31'b0, irq}, 32'd1);
        csr_wr(EN, 32'h02);
        check("R5 irq masked", {31'b0, irq}, 32'd0);

        // R10 fault and clear on the same bit in one cycle
        csr_wr(ST, 32'h3F);
        do_read(32'h3000_0000, 8'd17, 16'hFFFF, 0);
        @(negedge clk);
        s_read = 1'b1; s_address = 32'h3000_0000; s_burstcount = 8'd1;
        s_byteenable = 16'hFFFF; s_waitreq = 1'b0;
        csr_write = 1'b1; csr_addr = ST; csr_wdata = 32'h21;
        @(negedge clk);
        s_read = 1'b0; csr_write = 1'b0;
        csr_rd(ST, v); check("R10 set wins", v, 32'h01);
        csr_wr(ST, 32'h3F); exp_st = '0;

        // R11 stalled cycles carry no transfer
        @(negedge clk);
        s_read = 1'b1; s_address = 32'h5000_0000; s_burstcount = 8'd40;
        s_byteenable = 16'h0005; s_waitreq = 1'b1;
        repeat (4) @(negedge clk);
        s_read = 1'b0;
        @(negedge clk);
        s_waitreq = 1'b0;
        csr_rd(ST, v); check("R11 stall ignored", v, 32'd0);

        // Random traffic
        for (int it = 0; it < 40; it++) begin
            logic [31:0] a;
            logic [7:0]  bc;
            logic [15:0] b0, b1;
            int          pick;
            pick = int'($urandom_range(0, 4));
            case (pick)
                0: a = 32'h1000_0000 | ($urandom & 32'h0FFF_FFF0);
                1: a = 32'h2000_0000 | ($urandom & 32'h00FF_FFF0);
                2: a = 32'h3000_0000 | ($urandom & 32'h0FFF_FFF0);
                3: a = 32'h4000_0000 | ($urandom & 32'h0001_FFF0);
                default: a = $urandom;
            endcase
            bc = 8'($urandom_range(1, 22));
            b0 = ($urandom_range(0, 1) == 0) ? 16'($urandom) : 16'hFF00;
            b1 = ($urandom_range(0, 1) == 0) ? 16'($urandom) : 16'h00FF;
            if ($urandom_range(0, 1) == 0)
                do_read(a, bc, b0, int'($urandom_range(0, 2)));
            else
                do_write(a, bc, b0, b1, int'($urandom_range(0, 2)));
            verify("R2 R6 R7 R8 R9 random");
        end

        $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
        $finish;
    end

    initial begin
        repeat (150000) @(posedge clk);
        n_checks++;
        n_fail++;
        $display("FAIL watchdog: actual hung expected done");
        $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
        $finish;
    end
endmodule